// File: doc/BRIEF.md
# Serial-Access Watchdog with Time-Counter Freeze

This block sits between the serial register port of a real-time clock and its seconds-counting chain. A host access begins when the chip enable is high and the serial front end strobes a valid subaddress. From then on the block holds the time counters frozen, so that a multi-byte read or write sees a consistent time. A 1 Hz tick that arrives during the access is remembered and delivered as one seconds-advance pulse when the freeze ends. A short access therefore loses no time.

If the host never ends the access, a coarse watchdog built on the same 1 Hz tick forces the front end clear. It trips on the second tick seen after the subaddress, which falls between one and two seconds into the access. On a trip it pulses an abort to the serial front end, releases the counters with the one remembered second, and discards the other. It then refuses new accesses until the chip enable has been seen low.

The controller has four states. `GS_IDLE`: counters run and ticks pass straight through. `GS_HOLD`: frozen, with no tick seen yet. `GS_HOLD_TICKED`: frozen, with one tick pending. `GS_LOCKOUT`: counters run and strobes are ignored until the enable drops. Transitions: *start* (IDLE→HOLD on a strobe with enable high), *first tick* (HOLD→HOLD_TICKED), *release* (HOLD or HOLD_TICKED→IDLE on enable low), *trip* (HOLD_TICKED→LOCKOUT on a tick with enable high) and *unlock* (LOCKOUT→IDLE on enable low). A synchronous reset returns the controller to IDLE.

Top module: `rtc_access_guard`

## Requirements
- R1: `freeze` rises in the cycle after a clock edge that samples `subaddr_valid` and `chip_en` both high while not locked out. `chip_en` high without the strobe never raises `freeze`.
- R2: While `freeze` is high and `chip_en` is high, `sec_adv` stays low except in a trip cycle.
- R3: When `chip_en` is low in a frozen cycle, that cycle is the release. `sec_adv` pulses in it if a tick is pending or arrives in that cycle, and `freeze` is low from the next cycle.
- R4: At most one tick is held. A pending tick and a tick in the release cycle produce a single `sec_adv` pulse.
- R5: A trip happens when a tick arrives with `chip_en` high and one tick already pending, which is the second tick after the subaddress. `if_abort` is high for exactly that one cycle, `sec_adv` pulses once in it, and `freeze` is low from the next cycle. Each trip loses exactly one second.
- R6: `locked_out` is high from the cycle after a trip until the cycle after `chip_en` is sampled low. While it is high, `freeze` stays low and `subaddr_valid` strobes have no effect.
- R7: Whenever `freeze` is low, `sec_adv` equals `tick_1hz` in the same cycle, including the cycle of the starting strobe.
- R8: A synchronous reset (`rst` high at a clock edge) leaves `freeze`, `locked_out` and `if_abort` low, even from the lockout state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Serial chip-enable level |
| subaddr_valid | input | 1 | One-cycle strobe: a valid subaddress has been received |
| tick_1hz | input | 1 | One-cycle 1 Hz timebase pulse |
| freeze | output | 1 | Time counters held while high |
| sec_adv | output | 1 | One-cycle seconds-advance pulse to the counters |
| if_abort | output | 1 | One-cycle pulse that clears the serial front end on a trip |
| locked_out | output | 1 | Access refused until chip enable is sampled low |

## Verification
A wrong state shows up at the ports within one clock. A controller stuck frozen swallows the next pass-through tick. A lost pending flag drops the pulse expected at release. A wrong tick count moves `if_abort` one tick early or late, or never raises it. The bench's reference model predicts all four outputs every cycle, so any divergence is reported in the cycle where it first reaches a pin. Separate tallies of ticks and advances confirm that a trip costs exactly one second.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
    typedef enum logic [1:0] {
        GS_IDLE        = 2'd0,
        GS_HOLD        = 2'd1,
        GS_HOLD_TICKED = 2'd2,
        GS_LOCKOUT     = 2'd3
    } guard_state_t;
endpackage

// File: rtl/rtc_guard_fsm.sv
module rtc_guard_fsm
    import rtc_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         chip_en,
    input  logic         subaddr_valid,
    input  logic         tick_1hz,
    output guard_state_t state_q
);
    guard_state_t state_d;

    // Next-state selection; enable low always wins over a tick.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_IDLE: begin
                if (chip_en && subaddr_valid) state_d = GS_HOLD;          // start
            end
            GS_HOLD: begin
                if (!chip_en)      state_d = GS_IDLE;                      // release
                else if (tick_1hz) state_d = GS_HOLD_TICKED;               // first tick
            end
            GS_HOLD_TICKED: begin
                if (!chip_en)      state_d = GS_IDLE;                      // release
                else if (tick_1hz) state_d = GS_LOCKOUT;                   // trip
            end
            GS_LOCKOUT: begin
                if (!chip_en)      state_d = GS_IDLE;                      // unlock
            end
            default: state_d = GS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= GS_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/rtc_guard_outs.sv
module rtc_guard_outs
    import rtc_guard_pkg::*;
(
    input  guard_state_t state_q,
    input  logic         chip_en,
    input  logic         tick_1hz,
    output logic         freeze,
    output logic         sec_adv,
    output logic         if_abort,
    output logic         locked_out
);
    // Output decode; the pending tick is implied by GS_HOLD_TICKED.
    always_comb begin
        freeze     = 1'b0;
        sec_adv    = 1'b0;
        if_abort   = 1'b0;
        locked_out = 1'b0;
        unique case (state_q)
            GS_IDLE: begin
                sec_adv = tick_1hz;
            end
            GS_HOLD: begin
                freeze  = 1'b1;
                sec_adv = !chip_en && tick_1hz;
            end
            GS_HOLD_TICKED: begin
                freeze   = 1'b1;
                sec_adv  = !chip_en || tick_1hz;
                if_abort = chip_en && tick_1hz;
            end
            GS_LOCKOUT: begin
                locked_out = 1'b1;
                sec_adv    = tick_1hz;
            end
            default: begin
                sec_adv = tick_1hz;
            end
        endcase
    end
endmodule

// File: rtl/rtc_access_guard.sv
module rtc_access_guard
    import rtc_guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic chip_en,
    input  logic subaddr_valid,
    input  logic tick_1hz,
    output logic freeze,
    output logic sec_adv,
    output logic if_abort,
    output logic locked_out
);
    guard_state_t state_q;

    rtc_guard_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .chip_en       (chip_en),
        .subaddr_valid (subaddr_valid),
        .tick_1hz      (tick_1hz),
        .state_q       (state_q)
    );

    rtc_guard_outs u_outs (
        .state_q    (state_q),
        .chip_en    (chip_en),
        .tick_1hz   (tick_1hz),
        .freeze     (freeze),
        .sec_adv    (sec_adv),
        .if_abort   (if_abort),
        .locked_out (locked_out)
    );
endmodule

// File: rtl/rtc_access_guard_chk.sv
module rtc_access_guard_chk (
    input logic clk,
    input logic rst,
    input logic chip_en,
    input logic subaddr_valid,
    input logic tick_1hz,
    input logic freeze,
    input logic sec_adv,
    input logic if_abort,
    input logic locked_out
);
    a_r1_freeze_needs_strobe: assert property (@(posedge clk) disable iff (rst)
        $rose(freeze) |-> $past(chip_en && subaddr_valid));

    a_r2_no_advance_in_access: assert property (@(posedge clk) disable iff (rst)
        (freeze && chip_en && !if_abort) |-> !sec_adv);

    a_r3_release_unfreezes: assert property (@(posedge clk) disable iff (rst)
        (freeze && !chip_en) |=> !freeze);

    a_r5_abort_single: assert property (@(posedge clk) disable iff (rst)
        if_abort |=> !if_abort);

    a_r5_abort_advances: assert property (@(posedge clk) disable iff (rst)
        if_abort |-> (sec_adv && freeze && chip_en && tick_1hz));

    a_r6_lock_after_trip: assert property (@(posedge clk) disable iff (rst)
        if_abort |=> (locked_out && !freeze));

    a_r6_unlock_on_low: assert property (@(posedge clk) disable iff (rst)
        (locked_out && !chip_en) |=> !locked_out);

    a_r6_lock_holds: assert property (@(posedge clk) disable iff (rst)
        (locked_out && chip_en) |=> (locked_out && !freeze));

    a_r7_pass_through: assert property (@(posedge clk) disable iff (rst)
        !freeze |-> (sec_adv == tick_1hz));

    a_r8_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!freeze && !locked_out));
endmodule

bind rtc_access_guard rtc_access_guard_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .chip_en       (chip_en),
    .subaddr_valid (subaddr_valid),
    .tick_1hz      (tick_1hz),
    .freeze        (freeze),
    .sec_adv       (sec_adv),
    .if_abort      (if_abort),
    .locked_out    (locked_out)
);

// File: tb/test_rtc_access_guard.sv
`timescale 1ns/1ps
module test_rtc_access_guard;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_en = 1'b0, subaddr_valid = 1'b0, tick_1hz = 1'b0;
    logic freeze, sec_adv, if_abort, locked_out;

    int checks = 0, failures = 0;
    int ticks_in = 0, adv_out = 0;
    // reference model state
    bit m_access = 0;
    int m_ticks = 0;
    bit m_locked = 0;

    always #2.5 clk = ~clk;

    rtc_access_guard i_rtc_access_guard (
        .clk(clk), .rst(rst), .chip_en(chip_en), .subaddr_valid(subaddr_valid),
        .tick_1hz(tick_1hz), .freeze(freeze), .sec_adv(sec_adv),
        .if_abort(if_abort), .locked_out(locked_out)
    );

    task automatic chk(input string tag, input string name, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, name, act, exp, $time);
        end
    endtask

    task automatic step(input logic ce, input logic sa, input logic tk, input string tag);
        bit e_frz, e_adv, e_abt;
        @(negedge clk);
        chip_en = ce; subaddr_valid = sa; tick_1hz = tk;
        #1;
        e_frz = m_access; e_abt = 0;
        if (!m_access)     e_adv = tk;
        else if (!ce)      e_adv = (m_ticks > 0) || tk;
        else if (tk && m_ticks == 1) begin e_adv = 1; e_abt = 1; end
        else               e_adv = 0;
        chk(tag, "freeze", freeze, e_frz);
        chk(tag, "sec_adv", sec_adv, e_adv);
        chk(tag, "if_abort", if_abort, e_abt);
        chk(tag, "locked_out", locked_out, m_locked);
        if (tk) ticks_in++;
        if (sec_adv) adv_out++;
        // model advance to the next edge
        if (!m_access) begin
            if (m_locked) begin
                if (!ce) m_locked = 0;
            end else if (ce && sa) begin
                m_access = 1; m_ticks = 0;
            end
        end else if (!ce) begin
            m_access = 0;
        end else if (tk) begin
            if (m_ticks == 1) begin m_access = 0; m_locked = 1; end
            else m_ticks++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_access = 0; m_ticks = 0; m_locked = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int t0, a0;
        do_reset();
        step(0, 0, 0, "R8");
        // R7 idle pass-through
        step(0, 0, 1, "R7"); step(0, 0, 0, "R7"); step(0, 0, 1, "R7");
        // R1 enable high without strobe: no freeze, ticks pass
        step(1, 0, 0, "R1"); step(1, 0, 1, "R1"); step(1, 0, 0, "R1");
        // short access, no tick
        step(1, 1, 0, "R1"); step(1, 0, 0, "R2"); step(1, 0, 0, "R2");
        step(0, 0, 0, "R3"); step(0, 0, 0, "R3");
        // access with one tick, released later: pulse at release
        step(1, 1, 1, "R7"); step(1, 0, 1, "R2"); step(1, 0, 0, "R2");
        step(0, 0, 0, "R3"); step(0, 0, 0, "R3");
        // tick arriving in a release cycle with nothing pending
        step(1, 1, 0, "R1"); step(0, 0, 1, "R3"); step(0, 0, 0, "R3");
        // pending tick plus tick at release: one pulse
        step(1, 1, 0, "R1"); step(1, 0, 1, "R4"); step(0, 0, 1, "R4"); step(0, 0, 0, "R4");
        // trip scenario with loss accounting
        t0 = ticks_in; a0 = adv_out;
        step(1, 1, 0, "R1"); step(1, 0, 0, "R2"); step(1, 0, 1, "R2");
        step(1, 1, 0, "R2"); step(1, 0, 0, "R2");
        step(1, 0, 1, "R5");
        step(1, 0, 0, "R6"); step(1, 1, 0, "R6"); step(1, 0, 1, "R6"); step(1, 1, 1, "R6");
        step(0, 0, 0, "R6"); step(0, 0, 0, "R6");
        chk("R5", "seconds_lost", ((ticks_in - t0) - (adv_out - a0)) == 1, 1'b1);
        // new access accepted after unlock, trip again
        step(1, 1, 0, "R1"); step(1, 0, 1, "R2"); step(1, 0, 1, "R5"); step(1, 0, 0, "R6");
        // reset from lockout
        do_reset();
        step(1, 0, 0, "R8"); step(1, 0, 1, "R8");
        // after reset, with enable high, a strobe starts an access
        step(1, 1, 0, "R1"); step(1, 0, 0, "R2"); step(0, 0, 0, "R3"); step(0, 0, 0, "R7");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule